// File: doc/BRIEF.md
# Front-End Serial Record Packetiser

This block listens to a single serial data line coming back from a front-end electronics board and turns each record it carries into a cell-framed packet of 18-bit words for a record FIFO. The line idles low. The first high bit it sees is taken as the start bit, and that bit is counted as bit 0 of the record. A mode input, sampled at the start bit, picks one of two record formats. A command response has a fixed length. An event record has a 39-bit header, and the number of 15-bit pulse-height values that follow it is given by the number of set bits in a hit map inside that header.

The block first captures the whole record as left-aligned 16-bit words. It then writes the packet. The packet opens with a dummy header word that has correct parity. The payload words follow. The packet is split into eight-word cells, and each cell is followed by a status word that carries a truncate flag and a parity bit. An all-zero end marker closes the packet. The interrupt output is raised in the same cycle that the end marker is written. The FIFO almost-full input does not stall the block. It only decides the truncate flag of each cell.

Top module: `fe_pkt_formatter`

## Requirements
- R1: After reset, and while the line stays low, no FIFO write occurs and the interrupt is low. The first high bit seen on the line is bit 0 of a record.
- R2: With `cmd_mode` high at the start bit, the record is 32 bits long and becomes two payload words. Bit 0 goes to bit 15 of the first word, and bit 16 goes to bit 15 of the second word.
- R3: With `cmd_mode` low at the start bit, record bits 0 to 38 become three payload words. Bits 32 to 38 fill bits 15 to 9 of the third word, and its low nine bits are zero.
- R4: In event mode, the number of 15-bit values that follow the header equals the number of ones in record bits 3 to 20. Each value becomes one payload word: value bit 14 goes in word bit 15, and word bit 0 is zero.
- R5: The first word of a packet is 18'h38000. Its flags are 11 and its data field 16'h8000 is a dummy header with odd parity.
- R6: The packet is cut into cells of eight words each. The first word of a cell has bit 17 set, and bit 16 set only in the first cell. Every other data word has bits 17:16 at zero. The words after the last payload word in the final cell are zero.
- R7: Each cell is followed by a status word {truncate, parity, 16'h0}. The parity bit makes the count of ones over the cell's 128 data bits, the truncate bit and the parity bit odd.
- R8: The truncate bit is set when `fifo_afull` was high during any of the cell's eight data-word writes and the cell is not the last cell of the packet.
- R9: After the last status word comes one all-zero word. `pkt_irq` is high during exactly that write, and a packet's writes occupy consecutive cycles.
- R10: The serial line is ignored from the end of a record until the end marker has been written. `cmd_mode` is ignored after the start bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one serial bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_in | input | 1 | Serial data from the front-end board, idle low |
| cmd_mode | input | 1 | 1 selects command-response capture, 0 selects event capture |
| fifo_afull | input | 1 | Record FIFO almost-full flag |
| fifo_wr | output | 1 | Record FIFO write strobe |
| fifo_wdata | output | 18 | Record FIFO write word |
| pkt_irq | output | 1 | High for the cycle in which the end marker is written |

## Verification
The hardest behaviour to reach from the ports is a packet that spans several cells. Only a long event record produces one, and its length depends on a hit map buried inside its own header. The stimulus builds each event record from a chosen hit map, including the full 18-hit case that needs three cells and the counts of four and five that sit on each side of a cell boundary. Almost-full is held high through some of these packets so that the truncate rule is seen on both an inner cell and a final cell. In other runs the line is held high during emission, and the mode input is flipped after the start bit, so that both inputs can be checked as ignored.

// File: rtl/fefmt_pkg.sv
package fefmt_pkg;

  localparam int WORD_W     = 16;
  localparam int CELL_WORDS = 8;
  localparam int HDR_BITS   = 39;
  localparam int VAL_BITS   = 15;
  localparam int HIT_LSB    = 3;
  localparam logic [WORD_W-1:0] DUMMY_HDR = 16'h8000;

  typedef enum logic [1:0] {C_IDLE, C_SHIFT, C_HOLD} cap_st_t;
  typedef enum logic [1:0] {E_IDLE, E_CELL, E_END}   emit_st_t;

  // serial bits making up payload word widx
  function automatic int field_width(input logic cmd, input int widx);
    if (cmd || widx < 2) return WORD_W;
    if (widx == 2)       return HDR_BITS - 2 * WORD_W;
    return VAL_BITS;
  endfunction

  // move the w freshly shifted bits to the top of the word, zero fill below
  function automatic logic [WORD_W-1:0] left_align(input logic [WORD_W-1:0] v, input int w);
    return v << (WORD_W - w);
  endfunction

  // ones among cnt header bits starting at record bit 'first'; hdr bit 31 is record bit 0
  function automatic int hits_in(input logic [31:0] hdr, input int first, input int cnt);
    int n;
    n = 0;
    for (int k = 0; k < cnt; k++) n += int'(hdr[31 - first - k]);
    return n;
  endfunction

  // cells for npay payload words plus the dummy header word
  function automatic int cells_needed(input int npay);
    return (npay + CELL_WORDS) / CELL_WORDS;
  endfunction

  // parity bit giving an odd total over data bits, truncate and itself
  function automatic logic cell_parity(input logic data_xor, input logic trunc);
    return ~(data_xor ^ trunc);
  endfunction

endpackage

// File: rtl/fe_capture.sv
module fe_capture
  import fefmt_pkg::*;
#(
  parameter  int HIT_W     = 18,
  localparam int MAX_WORDS = 3 + HIT_W,
  localparam int IDX_W     = $clog2(MAX_WORDS + 1)
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                ser_i,
  input  logic                                cmd_mode_i,
  input  logic                                release_i,
  output logic                                cap_done_o,
  output logic [IDX_W-1:0]                    nwords_o,
  output logic [MAX_WORDS-1:0][WORD_W-1:0]    words_o
);

  cap_st_t          st;
  logic             mode_q;
  logic [WORD_W-1:0] sr;
  logic [4:0]       bcnt;
  logic [IDX_W-1:0] widx;
  logic [IDX_W-1:0] nvals;

  // named internal events
  logic [WORD_W-1:0] sr_nx;
  logic [4:0]        fw;
  logic              word_full;
  logic [IDX_W-1:0]  hits;
  logic              last_word;

  always_comb begin
    sr_nx     = {sr[WORD_W-2:0], ser_i};
    fw        = 5'(field_width(mode_q, int'(widx)));
    word_full = (st == C_SHIFT) && (bcnt + 5'd1 == fw);
    hits      = IDX_W'(hits_in({words_o[0], words_o[1]}, HIT_LSB, HIT_W));
    if (mode_q)           last_word = (widx == IDX_W'(1));
    else if (widx == IDX_W'(2)) last_word = (hits == '0);
    else                  last_word = (widx > IDX_W'(2)) && (widx == nvals + IDX_W'(2));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= C_IDLE;
      mode_q     <= 1'b0;
      sr         <= '0;
      bcnt       <= '0;
      widx       <= '0;
      nvals      <= '0;
      cap_done_o <= 1'b0;
      nwords_o   <= '0;
      words_o    <= '0;
    end else begin
      cap_done_o <= 1'b0;
      case (st)
        C_IDLE: if (ser_i) begin
          mode_q <= cmd_mode_i;
          sr     <= WORD_W'(1);
          bcnt   <= 5'd1;
          widx   <= '0;
          nvals  <= '0;
          st     <= C_SHIFT;
        end
        C_SHIFT: begin
          sr <= sr_nx;
          if (word_full) begin
            words_o[widx] <= left_align(sr_nx, int'(fw));
            bcnt          <= '0;
            widx          <= widx + IDX_W'(1);
            if (!mode_q && widx == IDX_W'(2)) nvals <= hits;
            if (last_word) begin
              st         <= C_HOLD;
              cap_done_o <= 1'b1;
              nwords_o   <= widx + IDX_W'(1);
            end
          end else begin
            bcnt <= bcnt + 5'd1;
          end
        end
        C_HOLD: if (release_i) st <= C_IDLE;
        default: st <= C_IDLE;
      endcase
    end
  end

  // R4: the word index never runs past the buffer
  a_r4_word_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_SHIFT) |-> (int'(widx) < MAX_WORDS));

  // R10: the format chosen at the start bit holds for the whole record
  a_r10_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_SHIFT && $past(st == C_SHIFT)) |-> $stable(mode_q));

endmodule

// File: rtl/pkt_emit.sv
module pkt_emit
  import fefmt_pkg::*;
#(
  parameter  int MAX_WORDS = 21,
  localparam int IDX_W     = $clog2(MAX_WORDS + 1),
  localparam int MAX_CELLS = (MAX_WORDS + CELL_WORDS) / CELL_WORDS,
  localparam int CI_W      = $clog2(MAX_CELLS + 1),
  localparam int SLOT_W    = $clog2(MAX_CELLS * CELL_WORDS + 1)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cap_done_i,
  input  logic [IDX_W-1:0]                  nwords_i,
  input  logic [MAX_WORDS-1:0][WORD_W-1:0]  words_i,
  input  logic                              af_i,
  output logic                              wr_en_o,
  output logic [WORD_W+1:0]                 wr_data_o,
  output logic                              irq_o,
  output logic                              busy_o
);

  emit_st_t         st;
  logic [CI_W-1:0]  ci;
  logic [CI_W-1:0]  ncells;
  logic [3:0]       pos;
  logic [IDX_W-1:0] np;
  logic             xacc;
  logic             af_seen;

  // named internal events
  logic [SLOT_W-1:0] slot;
  logic [IDX_W-1:0]  ridx;
  logic [WORD_W-1:0] dword;
  logic              is_data;
  logic              is_status;
  logic              last_cell;
  logic              trunc;
  logic              par;

  always_comb begin
    slot      = SLOT_W'(int'(ci) * CELL_WORDS + int'(pos));
    ridx      = IDX_W'(slot - SLOT_W'(1));
    if (slot == '0)                  dword = DUMMY_HDR;
    else if (int'(slot) <= int'(np)) dword = words_i[ridx];
    else                             dword = '0;
    is_data   = (st == E_CELL) && (pos < 4'(CELL_WORDS));
    is_status = (st == E_CELL) && (pos == 4'(CELL_WORDS));
    last_cell = (ci == ncells - CI_W'(1));
    trunc     = af_seen && !last_cell;
    par       = cell_parity(xacc, trunc);

    wr_en_o   = (st != E_IDLE);
    irq_o     = (st == E_END);
    busy_o    = (st != E_IDLE);
    if (is_data)        wr_data_o = {pos == '0, (pos == '0) && (ci == '0), dword};
    else if (is_status) wr_data_o = {trunc, par, {WORD_W{1'b0}}};
    else                wr_data_o = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= E_IDLE;
      ci      <= '0;
      ncells  <= '0;
      pos     <= '0;
      np      <= '0;
      xacc    <= 1'b0;
      af_seen <= 1'b0;
    end else begin
      case (st)
        E_IDLE: if (cap_done_i) begin
          np     <= nwords_i;
          ncells <= CI_W'(cells_needed(int'(nwords_i)));
          ci     <= '0;
          pos    <= '0;
          st     <= E_CELL;
        end
        E_CELL: begin
          if (is_data) begin
            xacc    <= (pos == '0) ? ^dword : (xacc ^ (^dword));
            af_seen <= (pos == '0) ? af_i : (af_seen | af_i);
            pos     <= pos + 4'd1;
          end else begin
            pos <= '0;
            if (last_cell) st <= E_END;
            else           ci <= ci + CI_W'(1);
          end
        end
        E_END:   st <= E_IDLE;
        default: st <= E_IDLE;
      endcase
    end
  end

  // R5: a packet opens with the control-cell dummy header right after capture
  a_r5_header_first: assert property (@(posedge clk) disable iff (!rst_n)
    cap_done_i |=> (wr_en_o && wr_data_o == {2'b11, DUMMY_HDR}));

  // R6: an announced cell starts only after capture or after a status word
  a_r6_announce_order: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && !is_status && wr_data_o[WORD_W+1]) |-> ($past(is_status) || $past(cap_done_i)));

  // R8: the final cell never reports truncation
  a_r8_no_trunc_last: assert property (@(posedge clk) disable iff (!rst_n)
    (is_status && last_cell) |-> !wr_data_o[WORD_W+1]);

  // R9: the interrupt accompanies the all-zero end marker
  a_r9_irq_marker: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (wr_en_o && wr_data_o == '0));

endmodule

// File: rtl/fe_pkt_formatter.sv
module fe_pkt_formatter
  import fefmt_pkg::*;
#(
  parameter  int HIT_W     = 18,
  localparam int MAX_WORDS = 3 + HIT_W,
  localparam int IDX_W     = $clog2(MAX_WORDS + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ser_in,
  input  logic        cmd_mode,
  input  logic        fifo_afull,
  output logic        fifo_wr,
  output logic [17:0] fifo_wdata,
  output logic        pkt_irq
);

  logic                             cap_done;
  logic [IDX_W-1:0]                 nwords;
  logic [MAX_WORDS-1:0][WORD_W-1:0] words;
  logic                             emit_busy;

  fe_capture #(.HIT_W(HIT_W)) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .ser_i      (ser_in),
    .cmd_mode_i (cmd_mode),
    .release_i  (pkt_irq),
    .cap_done_o (cap_done),
    .nwords_o   (nwords),
    .words_o    (words)
  );

  pkt_emit #(.MAX_WORDS(MAX_WORDS)) u_emit (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_done_i (cap_done),
    .nwords_i   (nwords),
    .words_i    (words),
    .af_i       (fifo_afull),
    .wr_en_o    (fifo_wr),
    .wr_data_o  (fifo_wdata),
    .irq_o      (pkt_irq),
    .busy_o     (emit_busy)
  );

  // R10: a new record is never handed over while a packet is being written
  a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    cap_done |-> !emit_busy);

endmodule

// File: tb/tb_fe_pkt_formatter.sv
module tb_fe_pkt_formatter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser_in = 1'b0;
  logic        cmd_mode = 1'b0;
  logic        fifo_afull = 1'b0;
  logic        fifo_wr;
  logic [17:0] fifo_wdata;
  logic        pkt_irq;

  int nchk = 0;
  int nerr = 0;

  logic [0:308] rec;
  logic [15:0]  pay [0:31];
  logic [17:0]  expw [0:63];
  logic [17:0]  got  [0:63];
  int           ne, nw, irq_at, irq_cnt;

  always #5 clk = ~clk;

  fe_pkt_formatter dut (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .cmd_mode(cmd_mode),
    .fifo_afull(fifo_afull), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata), .pkt_irq(pkt_irq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // expected stream from the requirements
  task automatic build_exp(input int npay, input bit afv);
    int total, ncell, ones, s;
    logic [15:0] d;
    bit tr, pb;
    total = npay + 1;
    ncell = (total + 7) / 8;
    ne = 0;
    for (int c = 0; c < ncell; c++) begin
      ones = 0;
      for (int k = 0; k < 8; k++) begin
        s = c * 8 + k;
        if (s == 0)         d = 16'h8000;
        else if (s <= npay) d = pay[s-1];
        else                d = 16'h0;
        ones += $countones(d);
        expw[ne] = {k == 0, (k == 0) && (c == 0), d};
        ne++;
      end
      tr = afv && (c != ncell - 1);
      pb = ((ones + int'(tr)) % 2) == 0;
      expw[ne] = {tr, pb, 16'h0};
      ne++;
    end
    expw[ne] = 18'h0;
    ne++;
  endtask

  // send rec[0:len-1], collect the packet, compare
  task automatic run_pkt(input bit m, input int len, input bit afv, input bit garb, input string name);
    int guard;
    string tag;
    cmd_mode = m;
    fifo_afull = afv;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      ser_in = rec[i];
      if (i == 2) cmd_mode = ~m;
    end
    @(negedge clk);
    ser_in = garb;
    nw = 0; irq_cnt = 0; irq_at = -1; guard = 0;
    while (guard < 400) begin
      if (fifo_wr && nw < 64) begin got[nw] = fifo_wdata; nw++; end
      if (pkt_irq) begin irq_cnt++; irq_at = nw - 1; break; end
      @(negedge clk);
      guard++;
    end
    ser_in = 1'b0;
    check(irq_cnt == 1, {"R9 irq seen ", name}, 32'(irq_cnt), 32'd1);
    check(nw == ne, {"R6 word count ", name}, 32'(nw), 32'(ne));
    check(irq_at == ne - 1, {"R9 irq on end marker ", name}, 32'(irq_at), 32'(ne - 1));
    for (int k = 0; k < ne && k < nw; k++) begin
      if (k == 0)             tag = "R5";
      else if (k == ne - 1)   tag = "R9";
      else if ((k % 9) == 8)  tag = "R7";
      else                    tag = "R6";
      check(got[k] === expw[k], {tag, " word ", name}, 32'(got[k]), 32'(expw[k]));
      if ((k % 9) == 8 && k != ne - 1)
        check(got[k][17] === expw[k][17], {"R8 truncate ", name}, 32'(got[k][17]), 32'(expw[k][17]));
    end
    guard = 0;
    repeat (12) begin
      @(negedge clk);
      if (fifo_wr) guard++;
    end
    check(guard == 0, {"R10 quiet after packet ", name}, 32'(guard), 32'd0);
    fifo_afull = 1'b0;
  endtask

  task automatic t_reset();
    int bad;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    bad = 0;
    repeat (10) begin
      @(negedge clk);
      if (fifo_wr || pkt_irq) bad++;
    end
    check(bad == 0, "R1 idle after reset", 32'(bad), 32'd0);
  endtask

  task automatic t_cmd(input bit afv, input string name);
    for (int i = 0; i < 309; i++) rec[i] = 1'($urandom);
    rec[0] = 1'b1;
    pay[0] = rec[0:15];
    pay[1] = rec[16:31];
    build_exp(2, afv);
    check(pay[0][15] == 1'b1, {"R2 start bit at word msb ", name}, 32'(pay[0]), 32'h8000);
    run_pkt(1'b1, 32, afv, 1'b0, name);
  endtask

  task automatic t_event(input logic [17:0] hm, input bit afv, input bit garb, input string name);
    int n;
    for (int i = 0; i < 309; i++) rec[i] = 1'($urandom);
    rec[0] = 1'b1;
    for (int k = 0; k < 18; k++) rec[3 + k] = hm[17 - k];
    n = $countones(hm);
    pay[0] = rec[0:15];
    pay[1] = rec[16:31];
    pay[2] = {rec[32:38], 9'b0};
    for (int k = 0; k < n; k++) pay[3 + k] = {rec[39 + 15 * k +: 15], 1'b0};
    build_exp(3 + n, afv);
    run_pkt(1'b0, 39 + 15 * n, afv, garb, name);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    t_reset();
    t_cmd(1'b0, "R2 command response");
    t_event(18'h0, 1'b0, 1'b0, "R3 event no hits");
    t_event(18'b100000001000100001, 1'b0, 1'b0, "R4 four hits one cell");
    t_event(18'b110000001000100001, 1'b0, 1'b1, "R10 five hits line high");
    t_event(18'h3FFFF, 1'b1, 1'b0, "R8 full map afull");
    t_cmd(1'b1, "R8 single cell afull");
    t_event(18'b101101101101101101, 1'b1, 1'b1, "R7 twelve hits afull");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

endmodule